// File: doc/BRIEF.md
# Vertical-first element step unit

This unit holds the loop position of a vertical-first vector loop. It stores a vector length and two element pointers: one for source operands and one for the destination operand. Every issued operation runs a single scalar element. The unit turns the operation's register fields into physical register numbers. An operand flagged as vector gets the matching pointer added to its base register. An operand flagged as scalar keeps its base register unchanged.

Normal operations never move the pointers. They move only when software issues an explicit step command. That command advances both pointers together. When its record flag is set, it also writes the equal bit of condition field 0, so that an ordinary conditional branch can close the loop.

A separate branch-side port keeps a loop count register. A load sets the register. A decrement takes away the number of vertical elements the loop body executed.

Top module: `vf_step_unit`

## Requirements
- R1: After reset the vector length, both pointers and the cr0 equal bit are 0. A length write stores the value, clamped to VL_MAX (64) when the value is larger, and clears both pointers on the next edge.
- R2: Both pointers keep their values in any cycle with no step command and no length write, whatever operand fields are presented.
- R3: For each source operand, the index is the base plus the source pointer when its vector flag is 1, and the base unchanged when the flag is 0. Operand i takes bits [7i+6:7i] of the packed base bus and bit i of the flag bus.
- R4: The destination index is the destination base plus the destination pointer when its vector flag is 1, and the base unchanged when the flag is 0.
- R5: A step command raises each pointer by one, on the next edge, while that pointer is below the vector length.
- R6: A step with the record flag set writes the cr0 equal bit as (source pointer after the step == vector length). A step with the record flag clear moves the pointers and leaves the bit unchanged. No other event writes the bit.
- R7: Once a pointer equals the vector length, further steps leave it unchanged, with no wrap. With the record flag set, the equal bit stays 1.
- R8: The loop count register loads on ld_en, with ld_en winning over a decrement in the same cycle. A decrement subtracts the element count. If that count is greater than or equal to the register, the register becomes 0. The zero flag is 1 exactly while the register holds 0, and the reset value is 0.
- R9: A vector operand whose base plus pointer exceeds 127 sets its error bit and drives index 127. Error bit i belongs to source i, and bit NSRC belongs to the destination.
- R10: A length write in the same cycle as a step command takes priority: the pointers end at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vl_wr_en | input | 1 | Write vector length |
| vl_wr_data | input | 7 | New vector length |
| step_en | input | 1 | Explicit step command |
| step_rc | input | 1 | Record flag of the step command |
| src_base | input | 14 | Packed source base registers |
| src_vec | input | 2 | Per-source vector flag |
| dst_base | input | 7 | Destination base register |
| dst_vec | input | 1 | Destination vector flag |
| src_idx | output | 14 | Packed effective source indices |
| dst_idx | output | 7 | Effective destination index |
| idx_err | output | 3 | Out-of-range flags (sources, then destination) |
| vl | output | 7 | Current vector length |
| src_step | output | 7 | Source element pointer |
| dst_step | output | 7 | Destination element pointer |
| cr0_eq | output | 1 | Condition field 0 equal bit |
| ctr_ld_en | input | 1 | Load loop count |
| ctr_ld_data | input | 16 | Loop count load value |
| ctr_dec_en | input | 1 | Decrement loop count |
| ctr_dec_amt | input | 7 | Vertical elements executed |
| loop_cnt | output | 16 | Loop count register |
| ctr_zero | output | 1 | Loop count is zero |

## Verification
Some rules are checked on every cycle by the assertions. The pointers never move without a step or length write. A step raises them by exactly one below the length and they never pass it. A length write clears them. The cr0 bit changes only on a recorded step. The loop count never rises on a decrement. An out-of-range operand always drives index 127.

Other behaviour depends on specific values, so only the bench scenarios can show it. The exact index sums for mixed scalar and vector operands, the clamping of an oversized length, the equal bit staying set under saturated steps, and the floor-at-zero values of the loop count all fall in this group.

// File: rtl/vf_step_pkg.sv
// Package: shared sizing helpers for the vertical-first step unit.
// Assumes pointers never need more bits than register indices.
package vf_step_pkg;

    // Bits needed to hold the values 0..max inclusive.
    function automatic int unsigned bits_for(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/vf_step_ctr.sv
// Module: vf_step_ctr
// Holds the vector length, the source and destination element pointers
// and the cr0 equal bit. The pointers move only on an explicit step
// command. They saturate at the vector length. A length write clears
// them and wins over a step in the same cycle.
// Assumes VL_MAX fits in STEP_W bits.
module vf_step_ctr #(
    parameter int unsigned VL_MAX = 64,
    parameter int unsigned STEP_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vl_wr_en,
    input  logic [STEP_W-1:0] vl_wr_data,
    input  logic              step_en,
    input  logic              step_rc,
    output logic [STEP_W-1:0] vl_q,
    output logic [STEP_W-1:0] src_q,
    output logic [STEP_W-1:0] dst_q,
    output logic              eq_q
);

    localparam logic [STEP_W-1:0] VL_CAP = STEP_W'(VL_MAX);

    logic [STEP_W-1:0] vl_clamped;
    logic [STEP_W-1:0] src_nxt;
    logic [STEP_W-1:0] dst_nxt;

    // Limit a requested length to the supported maximum.
    always_comb begin
        vl_clamped = (vl_wr_data > VL_CAP) ? VL_CAP : vl_wr_data;
    end

    // Saturating next values of both pointers for a step command.
    always_comb begin
        src_nxt = (src_q < vl_q) ? src_q + STEP_W'(1) : src_q;
        dst_nxt = (dst_q < vl_q) ? dst_q + STEP_W'(1) : dst_q;
    end

    // Length and pointer registers; a length write beats a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_q  <= '0;
            src_q <= '0;
            dst_q <= '0;
        end else if (vl_wr_en) begin
            vl_q  <= vl_clamped;
            src_q <= '0;
            dst_q <= '0;
        end else if (step_en) begin
            src_q <= src_nxt;
            dst_q <= dst_nxt;
        end
    end

    // Equal bit, written only by a recorded step that the length write did not block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eq_q <= 1'b0;
        end else if (!vl_wr_en && step_en && step_rc) begin
            eq_q <= (src_nxt == vl_q);
        end
    end

endmodule

// File: rtl/vf_operand_map.sv
// Module: vf_operand_map
// Maps one operand field to a physical register index. A vector
// operand adds the element pointer to its base. A scalar operand
// passes the base through. A sum above the index range raises err
// and drives the top index, with no wrap.
// Assumes STEP_W <= REG_W.
module vf_operand_map #(
    parameter int unsigned REG_W  = 7,
    parameter int unsigned STEP_W = 7
) (
    input  logic [REG_W-1:0]  base,
    input  logic              is_vec,
    input  logic [STEP_W-1:0] step,
    output logic [REG_W-1:0]  idx,
    output logic              err
);

    localparam int unsigned SUM_W = REG_W + 1;

    logic [SUM_W-1:0] sum;

    // Widened sum so that overflow is visible in the carry bit.
    always_comb begin
        sum = SUM_W'(base) + SUM_W'(step);
    end

    // Select base or base-plus-step and flag out-of-range sums.
    always_comb begin
        err = is_vec && sum[REG_W];
        if (!is_vec) begin
            idx = base;
        end else if (sum[REG_W]) begin
            idx = '1;
        end else begin
            idx = sum[REG_W-1:0];
        end
    end

endmodule

// File: rtl/vf_loop_count.sv
// Module: vf_loop_count
// Branch-side loop count register. A load sets it. A decrement
// subtracts the number of vertical elements executed, with a floor
// at zero. The zero flag follows the register.
// Assumes DEC_W <= CNT_W.
module vf_loop_count #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned DEC_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_data,
    input  logic             dec_en,
    input  logic [DEC_W-1:0] dec_amt,
    output logic [CNT_W-1:0] cnt_q,
    output logic             zero
);

    logic [CNT_W-1:0] amt_w;
    logic [CNT_W-1:0] cnt_dec;

    // Decrement by the element count with a floor at zero.
    always_comb begin
        amt_w   = CNT_W'(dec_amt);
        cnt_dec = (amt_w >= cnt_q) ? '0 : cnt_q - amt_w;
    end

    // Count register; a load takes priority over a decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld_en) begin
            cnt_q <= ld_data;
        end else if (dec_en) begin
            cnt_q <= cnt_dec;
        end
    end

    // Zero flag follows the register in the same cycle.
    always_comb begin
        zero = (cnt_q == '0);
    end

endmodule

// File: rtl/vf_step_unit.sv
// Module: vf_step_unit (top)
// Element step state for a vertical-first loop: pointers, length,
// cr0 equal bit, operand-to-register mapping for NSRC sources and one
// destination, and a branch-side loop count register.
// Assumes the bits needed for VL_MAX do not exceed REG_W.
module vf_step_unit #(
    parameter int unsigned REG_W  = 7,
    parameter int unsigned VL_MAX = 64,
    parameter int unsigned NSRC   = 2,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned STEP_W = vf_step_pkg::bits_for(VL_MAX)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  vl_wr_en,
    input  logic [STEP_W-1:0]     vl_wr_data,
    input  logic                  step_en,
    input  logic                  step_rc,
    input  logic [NSRC*REG_W-1:0] src_base,
    input  logic [NSRC-1:0]       src_vec,
    input  logic [REG_W-1:0]      dst_base,
    input  logic                  dst_vec,
    output logic [NSRC*REG_W-1:0] src_idx,
    output logic [REG_W-1:0]      dst_idx,
    output logic [NSRC:0]         idx_err,
    output logic [STEP_W-1:0]     vl,
    output logic [STEP_W-1:0]     src_step,
    output logic [STEP_W-1:0]     dst_step,
    output logic                  cr0_eq,
    input  logic                  ctr_ld_en,
    input  logic [CNT_W-1:0]      ctr_ld_data,
    input  logic                  ctr_dec_en,
    input  logic [STEP_W-1:0]     ctr_dec_amt,
    output logic [CNT_W-1:0]      loop_cnt,
    output logic                  ctr_zero
);

    // Pointer, length and condition state.
    vf_step_ctr #(
        .VL_MAX (VL_MAX),
        .STEP_W (STEP_W)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .vl_wr_en   (vl_wr_en),
        .vl_wr_data (vl_wr_data),
        .step_en    (step_en),
        .step_rc    (step_rc),
        .vl_q       (vl),
        .src_q      (src_step),
        .dst_q      (dst_step),
        .eq_q       (cr0_eq)
    );

    // One mapper per source operand, all using the source pointer.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        vf_operand_map #(
            .REG_W  (REG_W),
            .STEP_W (STEP_W)
        ) u_map (
            .base   (src_base[i*REG_W +: REG_W]),
            .is_vec (src_vec[i]),
            .step   (src_step),
            .idx    (src_idx[i*REG_W +: REG_W]),
            .err    (idx_err[i])
        );
    end

    // Destination mapper using the destination pointer.
    vf_operand_map #(
        .REG_W  (REG_W),
        .STEP_W (STEP_W)
    ) u_dst_map (
        .base   (dst_base),
        .is_vec (dst_vec),
        .step   (dst_step),
        .idx    (dst_idx),
        .err    (idx_err[NSRC])
    );

    // Branch-side loop count.
    vf_loop_count #(
        .CNT_W (CNT_W),
        .DEC_W (STEP_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ctr_ld_en),
        .ld_data (ctr_ld_data),
        .dec_en  (ctr_dec_en),
        .dec_amt (ctr_dec_amt),
        .cnt_q   (loop_cnt),
        .zero    (ctr_zero)
    );

endmodule

// File: rtl/vf_step_chk.sv
// Module: vf_step_chk
// Property checker bound to vf_step_unit. It observes the ports only.
module vf_step_chk #(
    parameter int unsigned REG_W  = 7,
    parameter int unsigned VL_MAX = 64,
    parameter int unsigned NSRC   = 2,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned STEP_W = 7
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  vl_wr_en,
    input logic                  step_en,
    input logic                  step_rc,
    input logic [NSRC*REG_W-1:0] src_idx,
    input logic [REG_W-1:0]      dst_idx,
    input logic [NSRC:0]         idx_err,
    input logic [STEP_W-1:0]     vl,
    input logic [STEP_W-1:0]     src_step,
    input logic [STEP_W-1:0]     dst_step,
    input logic                  cr0_eq,
    input logic                  ctr_ld_en,
    input logic                  ctr_dec_en,
    input logic [CNT_W-1:0]      loop_cnt
);

    AST_LEN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        vl_wr_en |=> (src_step == '0 && dst_step == '0 && vl <= STEP_W'(VL_MAX))); // R1

    AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !vl_wr_en) |=> ($stable(src_step) && $stable(dst_step))); // R2

    AST_STEP_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !vl_wr_en && src_step < vl) |=> (src_step == $past(src_step) + STEP_W'(1))); // R5

    AST_CR0_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_en && step_rc && !vl_wr_en) |=> $stable(cr0_eq)); // R6

    AST_STEP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (src_step <= vl && dst_step <= vl)); // R7

    AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_dec_en && !ctr_ld_en) |=> (loop_cnt <= $past(loop_cnt))); // R8

    AST_DST_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        idx_err[NSRC] |-> (dst_idx == '1)); // R9

    AST_SRC0_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        idx_err[0] |-> (src_idx[REG_W-1:0] == '1)); // R9

endmodule

bind vf_step_unit vf_step_chk #(
    .REG_W  (REG_W),
    .VL_MAX (VL_MAX),
    .NSRC   (NSRC),
    .CNT_W  (CNT_W),
    .STEP_W (STEP_W)
) u_chk (.*);

// File: tb/sim_vf_step_unit.sv
`timescale 1ns/1ps
// Bench for vf_step_unit. It walks a table of operand cases, then runs directed tests.
module sim_vf_step_unit;

    typedef struct packed {
        logic [6:0] vl_in;
        logic [6:0] nstep;
        logic [6:0] b0;
        logic       v0;
        logic [6:0] b1;
        logic       v1;
        logic [6:0] db;
        logic       dv;
        logic [6:0] e_s0;
        logic [6:0] e_s1;
        logic [6:0] e_d;
        logic [2:0] e_err;
        logic [6:0] e_step;
        logic       e_eq;
    } row_t;

    localparam int NROW = 7;
    localparam row_t TBL [NROW] = '{
        '{7'd8,   7'd3,  7'd8,   1'b1, 7'd8,   1'b0, 7'd0,   1'b1, 7'd11,  7'd8,   7'd3,   3'b000, 7'd3,  1'b0},
        '{7'd8,   7'd3,  7'd8,   1'b0, 7'd8,   1'b1, 7'd0,   1'b0, 7'd8,   7'd11,  7'd0,   3'b000, 7'd3,  1'b0},
        '{7'd64,  7'd0,  7'd5,   1'b1, 7'd9,   1'b1, 7'd20,  1'b1, 7'd5,   7'd9,   7'd20,  3'b000, 7'd0,  1'b0},
        '{7'd64,  7'd10, 7'd120, 1'b1, 7'd117, 1'b1, 7'd100, 1'b1, 7'd127, 7'd127, 7'd110, 3'b001, 7'd10, 1'b0},
        '{7'd4,   7'd6,  7'd10,  1'b1, 7'd0,   1'b0, 7'd125, 1'b1, 7'd14,  7'd0,   7'd127, 3'b100, 7'd4,  1'b1},
        '{7'd0,   7'd2,  7'd3,   1'b1, 7'd4,   1'b1, 7'd5,   1'b1, 7'd3,   7'd4,   7'd5,   3'b000, 7'd0,  1'b1},
        '{7'd100, 7'd64, 7'd63,  1'b1, 7'd64,  1'b1, 7'd0,   1'b1, 7'd127, 7'd127, 7'd64,  3'b010, 7'd64, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vl_wr_en = 1'b0;
    logic [6:0]  vl_wr_data = '0;
    logic        step_en = 1'b0;
    logic        step_rc = 1'b0;
    logic [13:0] src_base = '0;
    logic [1:0]  src_vec = '0;
    logic [6:0]  dst_base = '0;
    logic        dst_vec = 1'b0;
    logic [13:0] src_idx;
    logic [6:0]  dst_idx;
    logic [2:0]  idx_err;
    logic [6:0]  vl;
    logic [6:0]  src_step;
    logic [6:0]  dst_step;
    logic        cr0_eq;
    logic        ctr_ld_en = 1'b0;
    logic [15:0] ctr_ld_data = '0;
    logic        ctr_dec_en = 1'b0;
    logic [6:0]  ctr_dec_amt = '0;
    logic [15:0] loop_cnt;
    logic        ctr_zero;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    vf_step_unit u0 (
        .clk(clk), .rst_n(rst_n), .vl_wr_en(vl_wr_en), .vl_wr_data(vl_wr_data),
        .step_en(step_en), .step_rc(step_rc), .src_base(src_base), .src_vec(src_vec),
        .dst_base(dst_base), .dst_vec(dst_vec), .src_idx(src_idx), .dst_idx(dst_idx),
        .idx_err(idx_err), .vl(vl), .src_step(src_step), .dst_step(dst_step),
        .cr0_eq(cr0_eq), .ctr_ld_en(ctr_ld_en), .ctr_ld_data(ctr_ld_data),
        .ctr_dec_en(ctr_dec_en), .ctr_dec_amt(ctr_dec_amt), .loop_cnt(loop_cnt),
        .ctr_zero(ctr_zero)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_vl(input int v);
        vl_wr_en = 1'b1; vl_wr_data = 7'(v);
        @(negedge clk);
        vl_wr_en = 1'b0;
    endtask

    task automatic do_step(input bit rc);
        step_en = 1'b1; step_rc = rc;
        @(negedge clk);
        step_en = 1'b0; step_rc = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2_000_000;
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R1, R6, R8).
        chk("R1 reset vl", int'(vl), 0);
        chk("R1 reset src_step", int'(src_step), 0);
        chk("R1 reset dst_step", int'(dst_step), 0);
        chk("R6 reset cr0_eq", int'(cr0_eq), 0);
        chk("R8 reset loop_cnt", int'(loop_cnt), 0);
        chk("R8 reset zero", int'(ctr_zero), 1);

        // Table walk (R3, R4, R5, R7, R9, R1 clamp).
        for (int r = 0; r < NROW; r++) begin
            write_vl(int'(TBL[r].vl_in));
            for (int s = 0; s < int'(TBL[r].nstep); s++) do_step(1'b1);
            src_base = {TBL[r].b1, TBL[r].b0};
            src_vec  = {TBL[r].v1, TBL[r].v0};
            dst_base = TBL[r].db;
            dst_vec  = TBL[r].dv;
            #1;
            chk("R3 src0 index", int'(src_idx[6:0]), int'(TBL[r].e_s0));
            chk("R3 src1 index", int'(src_idx[13:7]), int'(TBL[r].e_s1));
            chk("R4 dst index", int'(dst_idx), int'(TBL[r].e_d));
            chk("R9 error bits", int'(idx_err), int'(TBL[r].e_err));
            chk("R5 src_step", int'(src_step), int'(TBL[r].e_step));
            chk("R5 dst_step", int'(dst_step), int'(TBL[r].e_step));
            if (TBL[r].nstep != 0) chk("R7 cr0_eq", int'(cr0_eq), int'(TBL[r].e_eq));
            @(negedge clk);
        end
        chk("R1 vl clamp to 64", int'(vl), 64);

        // R7: saturated pointer stays put and the equal bit stays 1.
        do_step(1'b1);
        chk("R7 saturated src_step", int'(src_step), 64);
        chk("R7 eq held", int'(cr0_eq), 1);

        // R2: operand traffic without steps leaves pointers alone.
        write_vl(8);
        do_step(1'b0); do_step(1'b0);
        for (int k = 0; k < 5; k++) begin
            src_base = 14'(k * 37); src_vec = 2'(k); dst_base = 7'(k * 9); dst_vec = k[0];
            @(negedge clk);
        end
        chk("R2 src_step held", int'(src_step), 2);
        chk("R2 dst_step held", int'(dst_step), 2);

        // R6: a recorded step sets eq; a non-recorded step keeps it.
        write_vl(2);
        do_step(1'b1);
        chk("R6 eq after 1 of 2", int'(cr0_eq), 0);
        do_step(1'b1);
        chk("R6 eq after 2 of 2", int'(cr0_eq), 1);
        write_vl(4);
        chk("R6 eq kept by length write", int'(cr0_eq), 1);
        do_step(1'b0);
        chk("R6 rc clear keeps eq", int'(cr0_eq), 1);
        chk("R6 rc clear still steps", int'(src_step), 1);
        do_step(1'b1);
        chk("R6 recorded step clears eq", int'(cr0_eq), 0);

        // R10: length write beats a step in the same cycle.
        vl_wr_en = 1'b1; vl_wr_data = 7'd8; step_en = 1'b1; step_rc = 1'b1;
        @(negedge clk);
        vl_wr_en = 1'b0; step_en = 1'b0; step_rc = 1'b0;
        chk("R10 src_step cleared", int'(src_step), 0);
        chk("R10 dst_step cleared", int'(dst_step), 0);
        chk("R10 eq not written", int'(cr0_eq), 0);

        // R8: loop count load, decrement by elements, floor at zero.
        ctr_ld_en = 1'b1; ctr_ld_data = 16'd10;
        @(negedge clk);
        ctr_ld_en = 1'b0;
        chk("R8 load", int'(loop_cnt), 10);
        ctr_dec_en = 1'b1; ctr_dec_amt = 7'd3;
        @(negedge clk);
        chk("R8 dec by 3", int'(loop_cnt), 7);
        chk("R8 nonzero flag", int'(ctr_zero), 0);
        ctr_dec_amt = 7'd7;
        @(negedge clk);
        chk("R8 dec to zero", int'(loop_cnt), 0);
        chk("R8 zero flag", int'(ctr_zero), 1);
        @(negedge clk);
        chk("R8 stays at zero", int'(loop_cnt), 0);
        ctr_dec_en = 1'b0;
        ctr_ld_en = 1'b1; ctr_ld_data = 16'd5;
        @(negedge clk);
        ctr_ld_en = 1'b0;
        ctr_dec_en = 1'b1; ctr_dec_amt = 7'd9;
        @(negedge clk);
        chk("R8 floor on large dec", int'(loop_cnt), 0);
        ctr_ld_en = 1'b1; ctr_ld_data = 16'd300; ctr_dec_amt = 7'd4;
        @(negedge clk);
        ctr_ld_en = 1'b0; ctr_dec_en = 1'b0;
        chk("R8 load beats dec", int'(loop_cnt), 300);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule